// File: doc/BRIEF.md
# Interrupt Cause Register Controller

This block collects single-cycle event pulses from the rest of a network controller into a 32-bit cause register. It ANDs the register with a mask and drives one level-sensitive interrupt line. Software reads the cause register over a small register bus and acknowledges causes by writing ones to it. Separate write ports let software raise causes, enable mask bits and disable mask bits. A companion register picks mask bits that are removed by themselves when software acknowledges causes while the interrupt is up.

A group of low-priority causes (bits 2, 6, 9, 16, 17 and 18) is gathered into a summary "other" cause at bit 24. Acknowledging bit 24 also clears every member of the group. So a group cause that software never unmasked cannot hold the summary bit up and cause an endless interrupt loop. Bit 31 of the cause view reports that the interrupt is asserted. Bits 24 and 31 are never stored. They are always computed from the stored causes and the mask.

The register map, by word address on `bus_addr`, is:
- 0: cause view. Reads return the view. Writes clear causes (write 1 to clear).
- 1: cause set. Write 1s to raise causes. Reads return 0.
- 2: mask enable. Write 1s to enable mask bits. Reads return the mask.
- 3: mask disable. Write 1s to disable mask bits. Reads return 0.
- 4: auto-mask select. Read and write.
- 5: control. Bit 0 is the auto-mask enable.
- 6 and 7: reads return 0.

Top module: `intr_cause_ctrl`

## Requirements
- R1: After reset, the cause view, the mask, the auto-mask select and the control register all read as 0, and `irq_o` is low.
- R2: An `evt_i` bit at 1 sets the matching cause bit at the next rising clock edge. `evt_i` bits 24 and 31 are ignored.
- R3: A write to address 0 clears each cause bit whose data bit is 1. Cause bits written with 0 are left unchanged.
- R4: Cause bit 24 reads as 1 exactly when at least one of cause bits 2, 6, 9, 16, 17 or 18 is set.
- R5: A write to address 0 with data bit 24 at 1 also clears cause bits 2, 6, 9, 16, 17 and 18.
- R6: Cause bit 31 reads as 1 exactly when (cause AND mask) is nonzero over bits 30 to 0. `irq_o` always equals cause bit 31.
- R7: A write to address 2 sets the mask bits given by the 1s in the data. A write to address 3 clears them. A read of address 2 returns the mask. A read of address 1 or 3 returns 0.
- R8: A write to address 1 sets the cause bits given by the 1s in the data, and those bits feed into bit 24 like hardware events do.
- R9: When an event and a clear reach the same cause bit in the same cycle, the bit ends up set.
- R10: A write to address 0 while cause bit 31 is 1 and control bit 0 is 1 clears the mask bits selected by the auto-mask register (address 4). If control bit 0 is 0, the mask is left unchanged.
- R11: A set cause bit whose mask bit is 0 does not raise `irq_o` by itself. If it belongs to the group, it does raise `irq_o` when mask bit 24 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| evt_i | input | 32 | Event pulses, one per cause bit |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default parameters: a 32-bit register, the summary cause at bit 24, the asserted flag at bit 31, and the six-bit low-priority group. With these values, every bit position named in the requirements is used as written. Random writes to all six addresses, together with sparse random events, reach states where the auto-mask fires while the mask is partly set. They also reach states where an acknowledgement of the summary bit meets a new event on a group member in the same cycle.

// File: rtl/icc_pkg.sv
package icc_pkg;

   localparam int ICC_ADDR_W = 3;

   typedef enum logic [ICC_ADDR_W-1:0] {
      RA_CAUSE = 3'd0,
      RA_CSET  = 3'd1,
      RA_MSET  = 3'd2,
      RA_MCLR  = 3'd3,
      RA_AMSK  = 3'd4,
      RA_CTRL  = 3'd5
   } icc_addr_e;

   typedef struct packed {
      logic cause_ack;
      logic cause_raise;
      logic mask_en;
      logic mask_dis;
      logic amsk_wr;
      logic ctrl_wr;
   } icc_wr_t;

endpackage

// File: rtl/icc_regbus.sv
module icc_regbus
   import icc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                  bus_we,
   input  logic [ICC_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     cause_view,
   input  logic [DATA_W-1:0]     mask_q,
   input  logic [DATA_W-1:0]     amsk_q,
   input  logic                  am_en_q,
   output icc_wr_t               wr,
   output logic [DATA_W-1:0]     bus_rdata
);

   always_comb begin
      wr             = '0;
      wr.cause_ack   = bus_we && (bus_addr == RA_CAUSE);
      wr.cause_raise = bus_we && (bus_addr == RA_CSET);
      wr.mask_en     = bus_we && (bus_addr == RA_MSET);
      wr.mask_dis    = bus_we && (bus_addr == RA_MCLR);
      wr.amsk_wr     = bus_we && (bus_addr == RA_AMSK);
      wr.ctrl_wr     = bus_we && (bus_addr == RA_CTRL);
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_CAUSE: bus_rdata = cause_view;
         RA_MSET:  bus_rdata = mask_q;
         RA_AMSK:  bus_rdata = amsk_q;
         RA_CTRL:  bus_rdata[0] = am_en_q;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/icc_cause_store.sv
module icc_cause_store #(
   parameter int                DATA_W      = 32,
   parameter int                OTHER_BIT   = 24,
   parameter int                ASSERT_BIT  = 31,
   parameter logic [DATA_W-1:0] OTHER_GROUP = 32'h0007_0244
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_i,
   input  logic              ack_stb,
   input  logic              raise_stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] cause_view,
   output logic              asserted
);

   logic [DATA_W-1:0] raw_q;
   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] clr_vec;
   logic [DATA_W-1:0] pend;

   always_comb begin
      set_vec = evt_i | (raise_stb ? wdata : '0);
      clr_vec = '0;
      if (ack_stb) begin
         clr_vec = wdata;
         if (wdata[OTHER_BIT]) clr_vec = clr_vec | OTHER_GROUP;
      end
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == OTHER_BIT || i == ASSERT_BIT) begin : g_derived
         assign raw_q[i] = 1'b0;
      end else begin : g_stored
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            bit_q <= 1'b0;
            else if (set_vec[i])   bit_q <= 1'b1;
            else if (clr_vec[i])   bit_q <= 1'b0;
         end
         assign raw_q[i] = bit_q;
      end
   end

   always_comb begin
      cause_view            = raw_q;
      cause_view[OTHER_BIT] = |(raw_q & OTHER_GROUP);
      pend                  = cause_view & mask_q;
      pend[ASSERT_BIT]      = 1'b0;
      asserted              = |pend;
      cause_view[ASSERT_BIT] = asserted;
   end

endmodule

// File: rtl/icc_mask_ctrl.sv
module icc_mask_ctrl
   import icc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  icc_wr_t           wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              asserted,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] amsk_q,
   output logic              am_en_q
);

   logic auto_fire;

   assign auto_fire = wr.cause_ack && asserted && am_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         amsk_q  <= '0;
         am_en_q <= 1'b0;
      end else begin
         if (wr.mask_en)       mask_q <= mask_q | wdata;
         else if (wr.mask_dis) mask_q <= mask_q & ~wdata;
         else if (auto_fire)   mask_q <= mask_q & ~amsk_q;
         if (wr.amsk_wr)       amsk_q <= wdata;
         if (wr.ctrl_wr)       am_en_q <= wdata[0];
      end
   end

endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
   import icc_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                OTHER_BIT   = 24,
   parameter int                ASSERT_BIT  = 31,
   parameter logic [DATA_W-1:0] OTHER_GROUP = 32'h0007_0244
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [ICC_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [DATA_W-1:0]     evt_i,
   output logic                  irq_o
);

   if (OTHER_BIT >= DATA_W || ASSERT_BIT >= DATA_W || OTHER_BIT == ASSERT_BIT) begin : g_bad_pos
      $error("intr_cause_ctrl: summary bit positions out of range or equal");
   end
   if (OTHER_GROUP[OTHER_BIT] || OTHER_GROUP[ASSERT_BIT] || OTHER_GROUP == '0) begin : g_bad_grp
      $error("intr_cause_ctrl: group must be nonempty and exclude summary bits");
   end

   icc_wr_t           wr;
   logic [DATA_W-1:0] cause_view;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] amsk_q;
   logic              am_en_q;
   logic              asserted;

   icc_regbus #(.DATA_W(DATA_W)) u_bus (
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .cause_view (cause_view),
      .mask_q     (mask_q),
      .amsk_q     (amsk_q),
      .am_en_q    (am_en_q),
      .wr         (wr),
      .bus_rdata  (bus_rdata)
   );

   icc_cause_store #(
      .DATA_W      (DATA_W),
      .OTHER_BIT   (OTHER_BIT),
      .ASSERT_BIT  (ASSERT_BIT),
      .OTHER_GROUP (OTHER_GROUP)
   ) u_cause (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .ack_stb    (wr.cause_ack),
      .raise_stb  (wr.cause_raise),
      .wdata      (bus_wdata),
      .mask_q     (mask_q),
      .cause_view (cause_view),
      .asserted   (asserted)
   );

   icc_mask_ctrl #(.DATA_W(DATA_W)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr),
      .wdata    (bus_wdata),
      .asserted (asserted),
      .mask_q   (mask_q),
      .amsk_q   (amsk_q),
      .am_en_q  (am_en_q)
   );

   assign irq_o = asserted;

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
   parameter int                DATA_W      = 32,
   parameter int                OTHER_BIT   = 24,
   parameter int                ASSERT_BIT  = 31,
   parameter logic [DATA_W-1:0] OTHER_GROUP = 32'h0007_0244
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [2:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] evt_i,
   input logic              irq_o,
   input logic [DATA_W-1:0] cause_view,
   input logic [DATA_W-1:0] mask_q,
   input logic [DATA_W-1:0] amsk_q,
   input logic              am_en_q
);

   localparam logic [DATA_W-1:0] STORED =
      ~((DATA_W'(1) << OTHER_BIT) | (DATA_W'(1) << ASSERT_BIT));
   localparam logic [DATA_W-1:0] NO_FLAG = ~(DATA_W'(1) << ASSERT_BIT);

   AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == |(cause_view & mask_q & NO_FLAG)); // R6

   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      |(evt_i & STORED) |=> ((cause_view & $past(evt_i & STORED)) == $past(evt_i & STORED))); // R9

   AST_GROUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 3'd0 && bus_wdata[OTHER_BIT])
      |=> ((cause_view & OTHER_GROUP & ~$past(evt_i)) == '0)); // R5

   AST_AUTO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 3'd0 && irq_o && am_en_q)
      |=> ((mask_q & $past(amsk_q)) == '0)); // R10

   AST_MASK_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 3'd3) |=> ((mask_q & $past(bus_wdata)) == '0)); // R7

endmodule

bind intr_cause_ctrl icc_checker #(
   .DATA_W      (DATA_W),
   .OTHER_BIT   (OTHER_BIT),
   .ASSERT_BIT  (ASSERT_BIT),
   .OTHER_GROUP (OTHER_GROUP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .evt_i      (evt_i),
   .irq_o      (irq_o),
   .cause_view (cause_view),
   .mask_q     (mask_q),
   .amsk_q     (amsk_q),
   .am_en_q    (am_en_q)
);

// File: tb/sim_intr_cause_ctrl.sv
`timescale 1ns/1ps
module sim_intr_cause_ctrl;

   localparam logic [31:0] GROUP  = 32'h0007_0244;
   localparam logic [31:0] STORED = 32'h7EFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] evt_i = '0;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] m_cause = '0;
   logic [31:0] m_mask  = '0;
   logic [31:0] m_am    = '0;
   logic        m_en    = 1'b0;

   always #4 clk = ~clk;

   intr_cause_ctrl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_i     (evt_i),
      .irq_o     (irq_o)
   );

   function automatic logic [31:0] view(input logic [31:0] c, input logic [31:0] m);
      logic [31:0] v;
      v = c & STORED;
      if ((v & GROUP) != 0) v[24] = 1'b1;
      if ((v[30:0] & m[30:0]) != 0) v[31] = 1'b1;
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic model(input logic we, input logic [2:0] a, input logic [31:0] d,
                        input logic [31:0] ev);
      logic [31:0] ov, set, clr;
      ov  = view(m_cause, m_mask);
      set = ev;
      clr = '0;
      if (we) begin
         case (a)
            3'd0: begin
               clr = d | (d[24] ? GROUP : 32'h0);
               if (ov[31] && m_en) m_mask = m_mask & ~m_am;
            end
            3'd1: set = set | d;
            3'd2: m_mask = m_mask | d;
            3'd3: m_mask = m_mask & ~d;
            3'd4: m_am = d;
            3'd5: m_en = d[0];
            default: ;
         endcase
      end
      m_cause = ((m_cause & ~clr) | set) & STORED;
   endtask

   task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                       input logic [31:0] ev);
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d; evt_i = ev;
      @(posedge clk);
      model(we, a, d, ev);
      #1;
      bus_we = 1'b0; evt_i = '0; bus_wdata = '0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      rd(3'd0, 32'h0, "R1 cause");
      rd(3'd2, 32'h0, "R1 mask");
      rd(3'd4, 32'h0, "R1 automask");
      rd(3'd5, 32'h0, "R1 ctrl");
      check("R1 irq", {31'b0, irq_o}, 32'h0);
      rst_n = 1'b1;

      // R2 and R4: event on group bit 6 sets it and the summary bit
      step(1'b0, 3'd0, 32'h0, 32'h0000_0040);
      rd(3'd0, 32'h0100_0040, "R2 R4 event bit 6");
      // R11: masked cause alone does not raise the interrupt
      check("R11 irq masked", {31'b0, irq_o}, 32'h0);
      // R2: events on bits 24 and 31 are ignored
      step(1'b0, 3'd0, 32'h0, 32'h8100_0000);
      rd(3'd0, 32'h0100_0040, "R2 ignored derived bits");
      // R11: unmasked summary bit raises the interrupt
      step(1'b1, 3'd2, 32'h0100_0000, 32'h0);
      rd(3'd0, 32'h8100_0040, "R11 R6 summary unmasked");
      check("R11 irq via summary", {31'b0, irq_o}, 32'h1);
      // R8 software raise
      step(1'b1, 3'd1, 32'h0000_0001, 32'h0);
      rd(3'd0, 32'h8100_0041, "R8 raise bit 0");
      // R3 clear only bit 0
      step(1'b1, 3'd0, 32'h0000_0001, 32'h0);
      rd(3'd0, 32'h8100_0040, "R3 clear bit 0");
      // R5 acknowledging summary clears group members
      step(1'b1, 3'd1, 32'h0000_0008, 32'h0);
      step(1'b1, 3'd0, 32'h0100_0000, 32'h0);
      rd(3'd0, 32'h0000_0008, "R5 group cleared");
      check("R5 irq", {31'b0, irq_o}, 32'h0);
      step(1'b1, 3'd0, 32'h0000_0008, 32'h0);
      // R9 event wins over clear in the same cycle
      step(1'b1, 3'd1, 32'h0000_0200, 32'h0);
      step(1'b1, 3'd0, 32'h0000_0200, 32'h0000_0200);
      rd(3'd0, 32'h8100_0200, "R9 event wins");
      // R10 auto-mask
      step(1'b1, 3'd4, 32'h0100_0000, 32'h0);
      step(1'b1, 3'd5, 32'h0000_0001, 32'h0);
      rd(3'd4, 32'h0100_0000, "R10 automask readback");
      rd(3'd5, 32'h0000_0001, "R10 ctrl readback");
      step(1'b1, 3'd0, 32'h0, 32'h0);
      rd(3'd2, 32'h0, "R10 mask auto cleared");
      check("R10 irq", {31'b0, irq_o}, 32'h0);
      // R7 mask set and clear
      step(1'b1, 3'd2, 32'h0000_00F0, 32'h0);
      step(1'b1, 3'd3, 32'h0000_0030, 32'h0);
      rd(3'd2, 32'h0000_00C0, "R7 mask");
      rd(3'd1, 32'h0, "R7 addr 1 reads 0");
      rd(3'd3, 32'h0, "R7 addr 3 reads 0");
      // R10 disabled: mask unchanged
      step(1'b1, 3'd5, 32'h0, 32'h0);
      step(1'b1, 3'd2, 32'h0100_0000, 32'h0);
      step(1'b1, 3'd0, 32'h0, 32'h0);
      rd(3'd2, 32'h0100_00C0, "R10 disabled keeps mask");

      // Random phase, compared against the model (R6 and the rest)
      for (int i = 0; i < 600; i++) begin
         logic [2:0]  a;
         logic [31:0] d, ev;
         logic        we;
         a  = 3'($urandom_range(0, 5));
         we = ($urandom_range(0, 3) != 0);
         d  = $urandom & $urandom & $urandom;
         if ($urandom_range(0, 5) == 0) d = d | 32'h0100_0000;
         if (a == 3'd5) d = {31'b0, ($urandom_range(0, 3) != 0)};
         ev = ($urandom_range(0, 2) == 0) ? ($urandom & $urandom & $urandom & GROUP)
                                         : ($urandom & $urandom & $urandom & $urandom);
         step(we, a, d, ev);
         rd(3'd0, view(m_cause, m_mask), "R6 random cause view");
         rd(3'd2, m_mask, "R7 random mask");
         check("R6 random irq", {31'b0, irq_o}, {31'b0, view(m_cause, m_mask)[31]});
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule